// File: doc/BRIEF.md
# Delay Element Calibration Calculator

This block converts the raw counts of a delay-line calibration run into the delay of one element in picoseconds. It handles both a coarse chain and a fine chain. A start pulse captures a 16-bit reference clock period. With it come a 16-bit reference count and a 16-bit delay count for each of the two chains. The block then works out the per-element delay of each chain in turn, using one shared sequential divider.

For each chain, the result is ten times the period times the reference count, divided by twice the delay count times a chain constant. The constant is 88 for the coarse chain and 264 for the fine chain. Both products are formed at 64 bits, and the division is unsigned and truncating. The quotient is cut down to 32 bits. If a delay count is zero, or a quotient comes out as zero, the operation fails. When the operation ends, the block pulses `done` for one cycle together with an error flag. The two results are held on registered outputs until the next operation ends.

Top module: `dly_param_calc`

## Requirements
- R1: When `done` pulses with `err` low, `coarse_ps` equals floor((10·period·coarse_ref) / (2·coarse_dly·88)), truncated to 32 bits.
- R2: When `done` pulses with `err` low, `fine_ps` equals floor((10·period·fine_ref) / (2·fine_dly·264)), truncated to 32 bits.
- R3: Both products are formed without loss at 64 bits, so the largest counts (period = ref = 65535, delay count 1) give exact quotients.
- R4: A coarse delay count of zero ends the operation with `err` high, and both `coarse_ps` and `fine_ps` read zero.
- R5: A fine delay count of zero, with valid coarse inputs, ends the operation with `err` high and both outputs zero.
- R6: A coarse or fine quotient equal to zero (for example, a zero reference count or a tiny period) ends the operation with `err` high and both outputs zero.
- R7: The coarse chain is computed and checked before the fine chain. A coarse delay count of zero raises `done` within 4 cycles of the start pulse, without running any division.
- R8: `done` is high for exactly one cycle per accepted start.
- R9: A `start` pulse while an operation is in progress is ignored. Only the first operation's result appears, and no extra `done` follows.
- R10: After reset, `done`, `err`, `coarse_ps` and `fine_ps` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; inputs are captured on it when idle |
| ref_period | input | 16 | Reference clock period |
| coarse_ref | input | 16 | Coarse chain reference count |
| coarse_dly | input | 16 | Coarse chain delay count |
| fine_ref | input | 16 | Fine chain reference count |
| fine_dly | input | 16 | Fine chain delay count |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operation failed; valid with done |
| coarse_ps | output | 32 | Coarse element delay |
| fine_ps | output | 32 | Fine element delay |

## Verification
The bench targets the largest operands. A design that narrowed its products below 64 bits would wrap the numerator and return a wrong quotient. It checks a zero delay count on each chain separately, and reference counts that drive a quotient to zero. A design that skipped one of these checks would report success, or leave stale values on the outputs. The short latency of a coarse failure shows whether the coarse chain really is handled first. A second start issued during a division catches a design that restarts, corrupts its result, or produces an extra `done` pulse.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK_C,
    ST_RUN_C,
    ST_CHK_F,
    ST_RUN_F
  } dpc_state_t;

  localparam int CHAIN_N  = 2;
  localparam int CHAIN_C  = 0;
  localparam int CHAIN_F  = 1;
endpackage

// File: rtl/dpc_operand.sv
module dpc_operand #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 64,
  parameter int MUL   = 88
) (
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] ref_cnt,
  input  logic [CNT_W-1:0] dly_cnt,
  output logic [DIV_W-1:0] num,
  output logic [DIV_W-1:0] den
);
  localparam logic [DIV_W-1:0] NUM_K = DIV_W'(10);
  localparam logic [DIV_W-1:0] DEN_K = DIV_W'(2 * MUL);

  always_comb begin
    num = NUM_K * DIV_W'(period) * DIV_W'(ref_cnt);
    den = DEN_K * DIV_W'(dly_cnt);
  end
endmodule

// File: rtl/dpc_divider.sv
module dpc_divider #(
  parameter int W  = 64,
  parameter int QW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  output logic          done,
  output logic [QW-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [W:0]    trial;
  logic          fits;
  logic [W-1:0]  diff;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    fits  = trial >= {1'b0, den_q};
    diff  = trial[W-1:0] - den_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q  <= '0;
        quo_q  <= dividend;
        den_q  <= divisor;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quo_q <= {quo_q[W-2:0], fits};
        rem_q <= fits ? diff : trial[W-1:0];
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign quot = quo_q[QW-1:0];

  // R1 R2: remainder left by the final step is below the divisor
  assert_rem_below_den_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem_q < den_q));

  // R9: the sequencer never relaunches a running division
  assert_no_relaunch_R9: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy_q);
endmodule

// File: rtl/dly_param_calc.sv
module dly_param_calc #(
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 64,
  parameter int OUT_W   = 32,
  parameter int C_MUL   = 88,
  parameter int F_MUL   = 264
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] ref_period,
  input  logic [CNT_W-1:0] coarse_ref,
  input  logic [CNT_W-1:0] coarse_dly,
  input  logic [CNT_W-1:0] fine_ref,
  input  logic [CNT_W-1:0] fine_dly,
  output logic             done,
  output logic             err,
  output logic [OUT_W-1:0] coarse_ps,
  output logic [OUT_W-1:0] fine_ps
);
  import dpc_pkg::*;

  dpc_state_t       state;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] ref_q [CHAIN_N];
  logic [CNT_W-1:0] dly_q [CHAIN_N];
  logic [DIV_W-1:0] num_w [CHAIN_N];
  logic [DIV_W-1:0] den_w [CHAIN_N];
  logic             sel_q;
  logic             go_q;
  logic             div_done;
  logic [OUT_W-1:0] quot;
  logic [OUT_W-1:0] c_res_q;

  for (genvar g = 0; g < CHAIN_N; g++) begin : g_chain
    localparam int MUL = (g == CHAIN_C) ? C_MUL : F_MUL;
    dpc_operand #(.CNT_W(CNT_W), .DIV_W(DIV_W), .MUL(MUL)) i_opnd (
      .period (per_q),
      .ref_cnt(ref_q[g]),
      .dly_cnt(dly_q[g]),
      .num    (num_w[g]),
      .den    (den_w[g])
    );
  end

  dpc_divider #(.W(DIV_W), .QW(OUT_W)) i_div (
    .clk     (clk),
    .rst     (rst),
    .go      (go_q),
    .dividend(num_w[sel_q]),
    .divisor (den_w[sel_q]),
    .done    (div_done),
    .quot    (quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      per_q     <= '0;
      ref_q     <= '{default: '0};
      dly_q     <= '{default: '0};
      sel_q     <= 1'b0;
      go_q      <= 1'b0;
      c_res_q   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      coarse_ps <= '0;
      fine_ps   <= '0;
    end else begin
      done <= 1'b0;
      go_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          per_q          <= ref_period;
          ref_q[CHAIN_C] <= coarse_ref;
          dly_q[CHAIN_C] <= coarse_dly;
          ref_q[CHAIN_F] <= fine_ref;
          dly_q[CHAIN_F] <= fine_dly;
          state          <= ST_CHK_C;
        end
        ST_CHK_C: begin
          if (dly_q[CHAIN_C] == '0) begin
            done <= 1'b1; err <= 1'b1;
            coarse_ps <= '0; fine_ps <= '0;
            state <= ST_IDLE;
          end else begin
            sel_q <= 1'b0; go_q <= 1'b1;
            state <= ST_RUN_C;
          end
        end
        ST_RUN_C: if (div_done) begin
          if (quot == '0) begin
            done <= 1'b1; err <= 1'b1;
            coarse_ps <= '0; fine_ps <= '0;
            state <= ST_IDLE;
          end else begin
            c_res_q <= quot;
            state   <= ST_CHK_F;
          end
        end
        ST_CHK_F: begin
          if (dly_q[CHAIN_F] == '0) begin
            done <= 1'b1; err <= 1'b1;
            coarse_ps <= '0; fine_ps <= '0;
            state <= ST_IDLE;
          end else begin
            sel_q <= 1'b1; go_q <= 1'b1;
            state <= ST_RUN_F;
          end
        end
        ST_RUN_F: if (div_done) begin
          done  <= 1'b1;
          state <= ST_IDLE;
          if (quot == '0) begin
            err <= 1'b1; coarse_ps <= '0; fine_ps <= '0;
          end else begin
            err <= 1'b0; coarse_ps <= c_res_q; fine_ps <= quot;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4 R5 R6: failed operations report zero results
  assert_err_zero_out_R6: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (coarse_ps == '0 && fine_ps == '0));

  // R1 R2: successful results are nonzero and both counts were valid
  assert_ok_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (coarse_ps != '0 && fine_ps != '0
                        && dly_q[CHAIN_C] != '0 && dly_q[CHAIN_F] != '0));

  // R9: captured operands stay put while an operation runs
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(per_q) && $stable(ref_q[CHAIN_C])
      && $stable(dly_q[CHAIN_C]) && $stable(ref_q[CHAIN_F])
      && $stable(dly_q[CHAIN_F])));

  // R7: fine division is only launched after a coarse one finished
  assert_coarse_first_R7: assert property (@(posedge clk) disable iff (rst)
    (go_q && sel_q) |-> (state == ST_RUN_F));
endmodule

// File: tb/test_dly_param_calc.sv
module test_dly_param_calc;
  typedef struct packed {
    logic        e;
    logic [31:0] c;
    logic [31:0] f;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [15:0] per = '0, cref = '0, cdly = '0, fref = '0, fdly = '0;
  logic done, err;
  logic [31:0] cps, fps;

  int checks = 0, fails = 0, done_cnt = 0;
  exp_t sb[$];
  string tag_q[$];

  always #4 clk = ~clk;

  dly_param_calc i_dly_param_calc (
    .clk(clk), .rst(rst), .start(start), .ref_period(per),
    .coarse_ref(cref), .coarse_dly(cdly), .fine_ref(fref), .fine_dly(fdly),
    .done(done), .err(err), .coarse_ps(cps), .fine_ps(fps)
  );

  function automatic logic [31:0] dq(logic [15:0] p, logic [15:0] r,
                                     logic [15:0] d, int m);
    longint unsigned n, q;
    n = 64'd10 * longint'(p) * longint'(r);
    q = n / (64'd2 * longint'(d) * longint'(m));
    return q[31:0];
  endfunction

  function automatic exp_t model(logic [15:0] p, logic [15:0] cr, logic [15:0] cd,
                                 logic [15:0] fr, logic [15:0] fd);
    exp_t x;
    x = '{e: 1'b1, c: 32'd0, f: 32'd0};
    if (cd == 0) return x;
    x.c = dq(p, cr, cd, 88);
    if (x.c == 0) begin x.c = 0; return x; end
    if (fd == 0) begin x.c = 0; return x; end
    x.f = dq(p, fr, fd, 264);
    if (x.f == 0) begin x.c = 0; x.f = 0; return x; end
    x.e = 1'b0;
    return x;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every completion
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) check(1'b0, "R8", "done held two cycles", 1, 0);
      if (done) begin
        done_cnt++;
        if (sb.size() == 0) check(1'b0, "R9", "unexpected done", 1, 0);
        else begin
          exp_t x;
          string t;
          x = sb.pop_front();
          t = tag_q.pop_front();
          check(err == x.e, t, "err", err, x.e);
          check(cps == x.c, t, "coarse_ps", cps, x.c);
          check(fps == x.f, t, "fine_ps", fps, x.f);
        end
      end
      prev_done = done;
    end
  end

  task automatic op(string t, logic [15:0] p, logic [15:0] cr, logic [15:0] cd,
                    logic [15:0] fr, logic [15:0] fd);
    int n0;
    n0 = done_cnt;
    sb.push_back(model(p, cr, cd, fr, fd));
    tag_q.push_back(t);
    @(negedge clk);
    per = p; cref = cr; cdly = cd; fref = fr; fdly = fd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_cnt == n0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(done == 0 && err == 0, "R10", "done/err after reset", {done, err}, 0);
    check(cps == 0 && fps == 0, "R10", "outputs after reset", cps | fps, 0);

    op("R1", 16'd6000, 16'd100, 16'd500, 16'd100, 16'd200);
    op("R2", 16'd2500, 16'd4000, 16'd37, 16'd9000, 16'd11);
    op("R1", 16'd12345, 16'd777, 16'd3, 16'd1234, 16'd5);
    op("R3", 16'hFFFF, 16'hFFFF, 16'd1, 16'hFFFF, 16'd1);
    op("R3", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    op("R4", 16'd6000, 16'd100, 16'd0, 16'd100, 16'd200);
    op("R5", 16'd6000, 16'd100, 16'd500, 16'd100, 16'd0);
    op("R6", 16'd6000, 16'd0, 16'd500, 16'd100, 16'd200);
    op("R6", 16'd6000, 16'd100, 16'd500, 16'd0, 16'd200);
    op("R6", 16'd1, 16'd1, 16'hFFFF, 16'd1, 16'd1);
    op("R2", 16'd6000, 16'd100, 16'd500, 16'd100, 16'd200);

    // R7: coarse failure ends quickly, before any division
    begin
      int n0, cyc;
      n0 = done_cnt;
      sb.push_back(model(16'd100, 16'd5, 16'd0, 16'd5, 16'd0));
      tag_q.push_back("R7");
      @(negedge clk);
      per = 16'd100; cref = 16'd5; cdly = 16'd0; fref = 16'd5; fdly = 16'd0;
      start = 1'b1;
      cyc = 0;
      @(negedge clk);
      start = 1'b0;
      while (done_cnt == n0 && cyc < 200) begin @(negedge clk); cyc++; end
      check(cyc <= 4, "R7", "coarse error latency", cyc, 4);
    end

    // R9: second start during a division is ignored
    begin
      int n0;
      n0 = done_cnt;
      sb.push_back(model(16'd3000, 16'd50, 16'd7, 16'd60, 16'd9));
      tag_q.push_back("R9");
      @(negedge clk);
      per = 16'd3000; cref = 16'd50; cdly = 16'd7; fref = 16'd60; fdly = 16'd9;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      per = 16'd999; cref = 16'd1; cdly = 16'd0; fref = 16'd1; fdly = 16'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (done_cnt == n0) @(negedge clk);
      repeat (200) @(negedge clk);
      check(done_cnt == n0 + 1, "R9", "done count after busy start", done_cnt - n0, 1);
    end

    check(sb.size() == 0, "R8", "pending expectations", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule